// File: doc/BRIEF.md
# Streaming Logic Analyzer Capture Front-End

This block samples up to sixteen digital probe lines at a programmable rate and streams the samples, byte by byte, into a USB bridge that runs a synchronous 8-bit FIFO interface. The bridge supplies the interface clock and a busy flag. The bridge takes a byte only on a clock edge where the block offers one and busy is low. The bridge may stall at any time, so the block holds each offered byte until it is taken. A ring buffer of samples absorbs the stalls.

In narrow mode each sample is the low eight probe lines, sent as one byte. In wide mode each sample is all sixteen lines, sent as two bytes in a row. Wide mode halves the fastest sample rate. Probe lines pass through a two-flop synchronizer before they are sampled. If the ring buffer is full when a sample is due, that sample is discarded and a sticky overflow flag records the loss. When capture is switched off, the buffer drains to the bridge, and an idle output then reports that nothing is pending.

Top module: `la_stream_capture`

## Requirements
- R1: After reset `bridge_wr` is 0, `overflow` is 0 and `idle` is 1.
- R2: In narrow mode (`wide_mode`=0), one sample is taken every N interface clocks while `capture_en` is high, where N = max(`rate_div`, 2). Each sample is sent as one byte holding probe bits 7:0. For a probe pattern that counts up by one each clock, consecutive bytes sent differ by N modulo 256.
- R3: A byte is transferred on a rising clock edge where `bridge_wr`=1 and `bridge_busy`=0. While `bridge_busy` is 1, an offered byte stays offered and `bridge_data` does not change.
- R4: In wide mode (`wide_mode`=1), N = max(`rate_div`, 4). Each sample is sent as two transfers: probe bits 7:0 first, then probe bits 15:8. For a counting probe pattern, consecutive 16-bit words differ by N modulo 65536.
- R5: While the ring buffer is not full, no sample is lost or reordered, however the busy flag stalls. The number of samples delivered matches the number of sample periods in the capture window, within one.
- R6: A sample that falls due while the buffer holds DEPTH samples is discarded and sets `overflow`. `overflow` stays set, through draining and idling, until a cycle with `ovf_clear` high. If a new loss happens in that same cycle, the set takes priority over the clear.
- R7: When `capture_en` goes low, sampling stops. `idle` stays 0 while any sample or byte is still pending. `idle` goes to 1 only once everything has been sent. While `idle` is 1, `bridge_wr` is 0.
- R8: `wide_mode` and `rate_div` are expected to stay stable while `capture_en` is high. Consecutive sample strobes are never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock supplied by the bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_en | input | 1 | High to sample; low to stop and drain |
| wide_mode | input | 1 | 0: 8 lines, one byte per sample; 1: 16 lines, two bytes |
| rate_div | input | DIV_W | Sample period in clocks (clamped to the mode minimum) |
| ovf_clear | input | 1 | Pulse high to clear the overflow flag |
| probe_in | input | 16 | Asynchronous probe lines |
| bridge_busy | input | 1 | Bridge cannot accept a byte this cycle |
| bridge_data | output | 8 | Byte offered to the bridge |
| bridge_wr | output | 1 | A byte is offered on `bridge_data` |
| overflow | output | 1 | Sticky: at least one sample was dropped |
| idle | output | 1 | Capture off and nothing left to send |

## Verification
The bench builds the block with DEPTH=16 and DIV_W=8. With a buffer this small, randomly stalled streams in both modes come close to filling it. A long forced stall overruns it within about a hundred cycles, which brings the loss-and-clear sequence of the overflow flag within easy reach. The probe lines carry a free-running counter. This lets the sample spacing, the byte order and any missing sample be read directly from the byte stream. It also covers the clamped divider settings and the idle handshake during a stalled drain.

// File: rtl/la_stream_capture.sv
module la_stream_capture #(
  parameter int DEPTH = 64,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic             wide_mode,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             ovf_clear,
  input  logic [15:0]      probe_in,
  input  logic             bridge_busy,
  output logic [7:0]       bridge_data,
  output logic             bridge_wr,
  output logic             overflow,
  output logic             idle
);
  localparam int AW = $clog2(DEPTH);

  logic [15:0]      sync_a, sync_b;
  logic [DIV_W-1:0] per_cnt, min_n, eff_n;
  logic             tick;

  logic [15:0]      mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      level;
  logic             full, empty, push, drop;

  logic [15:0]      hold;
  logic             hold_vld, hi_phase;
  logic             accept, last, load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= probe_in;
      sync_b <= sync_a;
    end
  end

  assign min_n = wide_mode ? DIV_W'(4) : DIV_W'(2);
  assign eff_n = (rate_div < min_n) ? min_n : rate_div;
  assign tick  = capture_en && (per_cnt == eff_n - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !capture_en || tick) per_cnt <= '0;
    else                               per_cnt <= per_cnt + 1'b1;
  end

  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (level == '0);
  assign push  = tick && !full;
  assign drop  = tick && full;

  assign accept = hold_vld && !bridge_busy;
  assign last   = accept && (hi_phase || !wide_mode);
  assign load   = (!hold_vld || last) && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= sync_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (load) rp <= rp + 1'b1;
      level <= level + (AW+1)'(push) - (AW+1)'(load);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= '0;
      hold_vld <= 1'b0;
      hi_phase <= 1'b0;
    end else if (load) begin
      hold     <= mem[rp];
      hold_vld <= 1'b1;
      hi_phase <= 1'b0;
    end else if (last) begin
      hold_vld <= 1'b0;
      hi_phase <= 1'b0;
    end else if (accept) begin
      hi_phase <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (drop)      overflow <= 1'b1;
    else if (ovf_clear) overflow <= 1'b0;
  end

  assign bridge_wr   = hold_vld;
  assign bridge_data = hi_phase ? hold[15:8] : hold[7:0];
  assign idle        = !capture_en && empty && !hold_vld;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_wr && bridge_busy |=> bridge_wr && $stable(bridge_data));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clear |=> overflow);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !bridge_wr);

  p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/test_la_stream_capture.sv
module test_la_stream_capture;
  logic       clk = 0, rst_n = 0, capture_en = 0, wide_mode = 0, ovf_clear = 0;
  logic [7:0] rate_div = 3;
  logic [15:0] probe_in = 0;
  logic       bridge_busy = 0;
  wire  [7:0] bridge_data;
  wire        bridge_wr, overflow, idle;

  la_stream_capture #(.DEPTH(16), .DIV_W(8)) i_la_stream_capture (
    .clk, .rst_n, .capture_en, .wide_mode, .rate_div, .ovf_clear, .probe_in,
    .bridge_busy, .bridge_data, .bridge_wr, .overflow, .idle);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int busy_pct = 0, exp_n = 3, samples = 0;
  bit force_busy = 0, chk_en = 1, have_prev = 0, half = 0, was_stall = 0, done = 0;
  logic [15:0] prev = 0, word = 0;
  logic [7:0]  stall_data = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit step_ok(logic [15:0] a, logic [15:0] b, int n, bit w16);
    if (w16) return (b - a) == 16'(n);
    return 8'(b - a) == 8'(n);
  endfunction

  always @(negedge clk) begin
    probe_in = probe_in + 1;
    bridge_busy = force_busy || (($urandom % 100) < busy_pct);
    #1;
    if (rst_n) begin
      if (was_stall) check(bridge_wr && bridge_data == stall_data, "R3 hold", bridge_data, stall_data);
      was_stall = bridge_wr && bridge_busy;
      stall_data = bridge_data;
      if (bridge_wr && !bridge_busy) begin
        if (!wide_mode) begin
          if (have_prev && chk_en)
            check(step_ok(prev, {8'h0, bridge_data}, exp_n, 0), "R2 step", int'(8'(bridge_data - prev[7:0])), exp_n);
          prev = {8'h0, bridge_data}; have_prev = 1; samples++;
        end else if (!half) begin
          word[7:0] = bridge_data; half = 1;
        end else begin
          word[15:8] = bridge_data; half = 0;
          if (have_prev && chk_en)
            check(step_ok(prev, word, exp_n, 1), "R4 step/order", int'(word - prev), exp_n);
          prev = word; have_prev = 1; samples++;
        end
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
    #2;
  endtask

  task automatic run(bit w, int div, int n, int pct, int cyc);
    @(negedge clk);
    wide_mode = w; rate_div = 8'(div); exp_n = n; busy_pct = pct;
    have_prev = 0; half = 0; samples = 0; chk_en = 1;
    capture_en = 1;
    repeat (cyc) @(negedge clk);
    capture_en = 0; busy_pct = 0;
    wait_idle();
    check(idle && !bridge_wr, "R7 idle after drain", idle, 1);
    check(samples >= cyc / n - 1 && samples <= cyc / n + 1, "R5 sample count", samples, cyc / n);
    check(!overflow, "R5 no loss", overflow, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check(!bridge_wr && idle && !overflow, "R1 reset state", {bridge_wr, idle, overflow}, 3'b010);

    run(0, 3, 3, 30, 400);
    run(0, 0, 2, 20, 300);
    run(0, 7, 7, 60, 500);
    run(1, 5, 5, 30, 500);
    run(1, 1, 4, 35, 400);
    run(1, 9, 9, 70, 600);

    // R7: stop while stalled, data must remain pending
    @(negedge clk);
    wide_mode = 0; rate_div = 4; exp_n = 4; have_prev = 0; samples = 0;
    capture_en = 1; force_busy = 1;
    repeat (30) @(negedge clk);
    capture_en = 0;
    repeat (5) @(negedge clk);
    #2;
    check(!idle && bridge_wr, "R7 pending not idle", idle, 0);
    force_busy = 0;
    wait_idle();
    check(idle, "R7 idle reached", idle, 1);
    check(!overflow, "R6 no false overflow", overflow, 0);

    // R6: overrun the buffer
    @(negedge clk);
    rate_div = 2; exp_n = 2; chk_en = 0; have_prev = 0;
    capture_en = 1; force_busy = 1;
    repeat (120) @(negedge clk);
    #2;
    check(overflow, "R6 overflow set", overflow, 1);
    capture_en = 0; force_busy = 0;
    wait_idle();
    check(overflow, "R6 overflow sticky", overflow, 1);
    @(negedge clk); ovf_clear = 1;
    @(negedge clk); ovf_clear = 0;
    #2;
    check(!overflow, "R6 overflow cleared", overflow, 0);

    // R6: set wins over clear
    @(negedge clk);
    capture_en = 1; force_busy = 1;
    repeat (60) @(negedge clk);
    ovf_clear = 1;
    repeat (4) @(negedge clk);
    ovf_clear = 0;
    #2;
    check(overflow, "R6 set beats clear", overflow, 1);
    capture_en = 0; force_busy = 0;
    wait_idle();
    @(negedge clk); ovf_clear = 1;
    @(negedge clk); ovf_clear = 0;
    chk_en = 1;

    run(0, 5, 5, 45, 500);
    finish_all();
  end

  task automatic finish_all();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_all();
  end
endmodule